// File: doc/BRIEF.md
# Mirror-Shadowed Control Register Bank

This block is a small host-addressable register space that stands between a host read/write bus and the control registers of a core. Five live hardware controls drive the core: ADC configuration, ADC rate, ADC acquisition, serial-port configuration and an external-clock select bit. The host never reaches these directly. Each has a mirror copy in ordinary register space. The host edits the mirror and then commits it. To see a live value, the host first takes a snapshot and then reads the mirror back.

Commit and snapshot have no data of their own. Each is triggered by a host *read* of a reserved command address, and that read returns zero. A commit also raises a one-cycle apply strobe, so a serial-port slave can take up the new configuration. The core can update the live registers through a separate hardware write port. Alongside the mirrors, the block holds general read/write registers 16 and 32 bits wide, and read-only words fed by the core.

Top module: `mirror_reg_bank`

## Requirements
- R1: After reset, the outputs are adc_cfg=0x0040, adc_rate=0x0100, adc_acq=0x0008, spi_cfg=0 and ext_clk_sel=0. In spi_cfg, bit0 is clock polarity, bit1 is sample phase and bit2 is select active-high, so 0 means mode 0 with the select active low. Each mirror reads back the same default. The operating-mode mirror reads 0, general read/write registers read 0, and spi_apply is low.
- R2: The mirrors sit at 0x100 (ADC config), 0x102 (ADC rate), 0x104 (ADC acquisition), 0x106 (serial config) and 0x108 (operating mode). A host write to a mirror changes what that mirror reads back, but it leaves every hardware output unchanged until a commit.
- R3: A host read of 0x900 loads every hardware register from its mirror on that clock edge, truncated to the hardware width. Bit 4 of the operating-mode mirror goes to ext_clk_sel. The read returns 0. A host write to 0x900 or 0xA00 triggers nothing.
- R4: spi_apply is high for exactly the one cycle that follows each commit read edge, and it is low at all other times.
- R5: A host read of 0xA00 loads each mirror with its live hardware value, zero-extended, and returns 0.
- R6: Only bit 4 of the operating-mode mirror is exchanged with the hardware. Its other 15 bits are plain storage, and neither command alters them.
- R7: When bit i of hw_we is set, hardware register i loads from the low bits of hw_wdata. The order is ADC config, ADC rate, ADC acquisition, serial config, then external clock, which takes bit 0 of hw_wdata. The mirrors are not affected.
- R8: When a commit read and a hw_we update hit the same register in the same cycle, the commit wins.
- R9: The 16-bit registers at 0x200+2k (k<4) keep wr_data[15:0] and read back with the upper bits zero. The 32-bit registers at 0x300+4k (k<4) keep all 32 bits.
- R10: The read-only words at 0x400+4k (k<2) return ro_status[32k+31:32k]. Host writes to them are ignored.
- R11: An unmapped or misaligned address reads 0, and a write to it changes nothing.
- R12: rd_data takes its new value on the edge where rd_en is high and holds it while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 12 | Host byte address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_en | input | 1 | Host read strobe, also triggers commands |
| rd_data | output | 32 | Registered host read data |
| hw_we | input | 5 | Core-side per-register hardware write enables |
| hw_wdata | input | 16 | Core-side hardware write data |
| ro_status | input | 64 | Core-supplied read-only words |
| adc_cfg | output | 16 | Live ADC configuration |
| adc_rate | output | 16 | Live ADC rate |
| adc_acq | output | 16 | Live ADC acquisition setting |
| spi_cfg | output | 3 | Live serial-port configuration |
| ext_clk_sel | output | 1 | Live external clock select |
| spi_apply | output | 1 | One-cycle strobe after each commit |

## Verification
The hardest condition to reach is a live register that differs from its mirror in a way only a snapshot can reveal. The stimulus produces it by changing the live registers through hw_we to values the host never wrote. It then reads the mirrors before and after the 0xA00 command. A directed test puts a commit read and a conflicting hw_we on the same edge to settle priority. Another sets the operating-mode mirror with bits around bit 4 populated, to show that only that one bit moves.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_COMMIT,
      K_SNAP,
      K_MIRROR,
      K_RW16,
      K_RW32,
      K_RO
   } kind_e;

   localparam int unsigned NUM_SHADOW = 5;
   localparam int unsigned SH_ACFG    = 0;
   localparam int unsigned SH_RATE    = 1;
   localparam int unsigned SH_ACQ     = 2;
   localparam int unsigned SH_SPI     = 3;
   localparam int unsigned SH_OPMODE  = 4;

   localparam int unsigned STRIDE_MIR  = 2;
   localparam int unsigned STRIDE_R16  = 2;
   localparam int unsigned STRIDE_R32  = 4;

   function automatic int unsigned max4(int unsigned a, int unsigned b,
                                        int unsigned c, int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
   import mrb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned IDX_W      = 3,
   parameter int unsigned CMD_COMMIT = 32'h900,
   parameter int unsigned CMD_SNAP   = 32'hA00,
   parameter int unsigned MIR_BASE   = 32'h100,
   parameter int unsigned NUM_MIR    = 5,
   parameter int unsigned RW16_BASE  = 32'h200,
   parameter int unsigned NUM_RW16   = 4,
   parameter int unsigned RW32_BASE  = 32'h300,
   parameter int unsigned NUM_RW32   = 4,
   parameter int unsigned RO_BASE    = 32'h400,
   parameter int unsigned NUM_RO     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output kind_e             kind,
   output logic [IDX_W-1:0]  idx
);

   if (ADDR_W > 32) begin : g_bad_addr_w
      $error("mrb_decode: ADDR_W must not exceed 32");
   end
   if (CMD_COMMIT == CMD_SNAP) begin : g_bad_cmd
      $error("mrb_decode: command addresses must differ");
   end

   logic [31:0] a_w;
   assign a_w = 32'(addr);

   function automatic logic in_win(logic [31:0] a, int unsigned base,
                                   int unsigned n, int unsigned stride);
      return (a >= base) && (a < base + n * stride) &&
             (((a - base) % stride) == 0);
   endfunction

   function automatic logic [IDX_W-1:0] slot(logic [31:0] a, int unsigned base,
                                             int unsigned stride);
      return IDX_W'((a - base) / stride);
   endfunction

   always_comb begin
      kind = K_NONE;
      idx  = '0;
      if (a_w == CMD_COMMIT) begin
         kind = K_COMMIT;
      end else if (a_w == CMD_SNAP) begin
         kind = K_SNAP;
      end else if (in_win(a_w, MIR_BASE, NUM_MIR, STRIDE_MIR)) begin
         kind = K_MIRROR;
         idx  = slot(a_w, MIR_BASE, STRIDE_MIR);
      end else if (in_win(a_w, RW16_BASE, NUM_RW16, STRIDE_R16)) begin
         kind = K_RW16;
         idx  = slot(a_w, RW16_BASE, STRIDE_R16);
      end else if (in_win(a_w, RW32_BASE, NUM_RW32, STRIDE_R32)) begin
         kind = K_RW32;
         idx  = slot(a_w, RW32_BASE, STRIDE_R32);
      end else if (in_win(a_w, RO_BASE, NUM_RO, STRIDE_R32)) begin
         kind = K_RO;
         idx  = slot(a_w, RO_BASE, STRIDE_R32);
      end
   end

endmodule

// File: rtl/mrb_shadow.sv
module mrb_shadow #(
   parameter int unsigned     MIR_W      = 16,
   parameter int unsigned     HW_W       = 16,
   parameter int unsigned     LSB        = 0,
   parameter bit              FIELD_ONLY = 1'b0,
   parameter logic [HW_W-1:0] RST        = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [MIR_W-1:0] host_wdata,
   input  logic             commit,
   input  logic             snap,
   input  logic             hw_we,
   input  logic [HW_W-1:0]  hw_wdata,
   output logic [MIR_W-1:0] mirror_q,
   output logic [HW_W-1:0]  hw_q
);

   if (LSB + HW_W > MIR_W) begin : g_bad_field
      $error("mrb_shadow: field does not fit the mirror");
   end
   if (!FIELD_ONLY && LSB != 0) begin : g_bad_lsb
      $error("mrb_shadow: full-width pairs must start at bit 0");
   end

   localparam logic [MIR_W-1:0] MIR_RST = MIR_W'(RST) << LSB;

   logic [MIR_W-1:0] snap_val;

   if (FIELD_ONLY) begin : g_field
      always_comb begin
         snap_val              = mirror_q;
         snap_val[LSB +: HW_W] = hw_q;
      end
   end else begin : g_full
      assign snap_val = MIR_W'(hw_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mirror_q <= MIR_RST;
      end else if (snap) begin
         mirror_q <= snap_val;
      end else if (host_we) begin
         mirror_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hw_q <= RST;
      end else if (commit) begin
         hw_q <= mirror_q[LSB +: HW_W];
      end else if (hw_we) begin
         hw_q <= hw_wdata;
      end
   end

endmodule

// File: rtl/mrb_gp_file.sv
module mrb_gp_file #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned REG16_W  = 16,
   parameter int unsigned NUM_RW16 = 4,
   parameter int unsigned NUM_RW32 = 4,
   parameter int unsigned NUM_RO   = 2,
   parameter int unsigned IDX_W    = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we16,
   input  logic                     we32,
   input  logic [IDX_W-1:0]         idx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_RO*DATA_W-1:0] ro_status,
   output logic [DATA_W-1:0]        rd16,
   output logic [DATA_W-1:0]        rd32,
   output logic [DATA_W-1:0]        rdro
);

   if (REG16_W > DATA_W) begin : g_bad_w
      $error("mrb_gp_file: REG16_W exceeds DATA_W");
   end
   if (NUM_RW16 < 1 || NUM_RW32 < 1 || NUM_RO < 1) begin : g_bad_n
      $error("mrb_gp_file: every register group needs at least one entry");
   end

   logic [REG16_W-1:0] arr16 [NUM_RW16];
   logic [DATA_W-1:0]  arr32 [NUM_RW32];
   logic [DATA_W-1:0]  arrro [NUM_RO];

   for (genvar i = 0; i < NUM_RW16; i++) begin : g_r16
      logic [REG16_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we16 && idx == IDX_W'(i)) begin
            q <= wdata[REG16_W-1:0];
         end
      end
      assign arr16[i] = q;
   end

   for (genvar i = 0; i < NUM_RW32; i++) begin : g_r32
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we32 && idx == IDX_W'(i)) begin
            q <= wdata;
         end
      end
      assign arr32[i] = q;
   end

   for (genvar i = 0; i < NUM_RO; i++) begin : g_ro
      assign arrro[i] = ro_status[i*DATA_W +: DATA_W];
   end

   always_comb begin
      rd16 = '0;
      rd32 = '0;
      rdro = '0;
      for (int i = 0; i < NUM_RW16; i++) begin
         if (idx == IDX_W'(i)) rd16 = DATA_W'(arr16[i]);
      end
      for (int i = 0; i < NUM_RW32; i++) begin
         if (idx == IDX_W'(i)) rd32 = arr32[i];
      end
      for (int i = 0; i < NUM_RO; i++) begin
         if (idx == IDX_W'(i)) rdro = arrro[i];
      end
   end

endmodule

// File: rtl/mirror_reg_bank.sv
module mirror_reg_bank
   import mrb_pkg::*;
#(
   parameter int unsigned  ADDR_W      = 12,
   parameter int unsigned  DATA_W      = 32,
   parameter int unsigned  MIR_W       = 16,
   parameter int unsigned  ACFG_W      = 16,
   parameter int unsigned  RATE_W      = 16,
   parameter int unsigned  ACQ_W       = 16,
   parameter int unsigned  SPICF_W     = 3,
   parameter int unsigned  OPMODE_BIT  = 4,
   parameter int unsigned  NUM_RW16    = 4,
   parameter int unsigned  NUM_RW32    = 4,
   parameter int unsigned  NUM_RO      = 2,
   parameter int unsigned  CMD_COMMIT  = 32'h900,
   parameter int unsigned  CMD_SNAP    = 32'hA00,
   parameter int unsigned  MIR_BASE    = 32'h100,
   parameter int unsigned  RW16_BASE   = 32'h200,
   parameter int unsigned  RW32_BASE   = 32'h300,
   parameter int unsigned  RO_BASE     = 32'h400,
   parameter logic [ACFG_W-1:0]  ACFG_RST  = 16'h0040,
   parameter logic [RATE_W-1:0]  RATE_RST  = 16'h0100,
   parameter logic [ACQ_W-1:0]   ACQ_RST   = 16'h0008,
   parameter logic [SPICF_W-1:0] SPICF_RST = 3'b000,
   parameter logic               EXTCLK_RST = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   output logic [DATA_W-1:0]        rd_data,
   input  logic [NUM_SHADOW-1:0]    hw_we,
   input  logic [MIR_W-1:0]         hw_wdata,
   input  logic [NUM_RO*DATA_W-1:0] ro_status,
   output logic [ACFG_W-1:0]        adc_cfg,
   output logic [RATE_W-1:0]        adc_rate,
   output logic [ACQ_W-1:0]         adc_acq,
   output logic [SPICF_W-1:0]       spi_cfg,
   output logic                     ext_clk_sel,
   output logic                     spi_apply
);

   localparam int unsigned IDX_N = max4(NUM_SHADOW, NUM_RW16, NUM_RW32, NUM_RO);
   localparam int unsigned IDX_W = (IDX_N > 1) ? $clog2(IDX_N) : 1;

   if (MIR_W > DATA_W) begin : g_bad_mir
      $error("mirror_reg_bank: MIR_W exceeds DATA_W");
   end
   if (ACFG_W > MIR_W || RATE_W > MIR_W || ACQ_W > MIR_W || SPICF_W > MIR_W) begin : g_bad_hw
      $error("mirror_reg_bank: a hardware register is wider than its mirror");
   end
   if (OPMODE_BIT >= MIR_W) begin : g_bad_bit
      $error("mirror_reg_bank: OPMODE_BIT outside the mirror");
   end

   kind_e            kind;
   logic [IDX_W-1:0] idx;

   mrb_decode #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .CMD_COMMIT(CMD_COMMIT),
      .CMD_SNAP  (CMD_SNAP),
      .MIR_BASE  (MIR_BASE),
      .NUM_MIR   (NUM_SHADOW),
      .RW16_BASE (RW16_BASE),
      .NUM_RW16  (NUM_RW16),
      .RW32_BASE (RW32_BASE),
      .NUM_RW32  (NUM_RW32),
      .RO_BASE   (RO_BASE),
      .NUM_RO    (NUM_RO)
   ) u_decode (
      .addr(addr),
      .kind(kind),
      .idx (idx)
   );

   logic commit, snap;
   assign commit = rd_en && (kind == K_COMMIT);
   assign snap   = rd_en && (kind == K_SNAP);

   logic [NUM_SHADOW-1:0] mir_we;
   for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_mir_we
      assign mir_we[i] = wr_en && (kind == K_MIRROR) && (idx == IDX_W'(i));
   end

   logic [MIR_W-1:0] mir_q [NUM_SHADOW];
   logic [0:0]       ext_q;

   mrb_shadow #(.MIR_W(MIR_W), .HW_W(ACFG_W), .LSB(0), .FIELD_ONLY(1'b0), .RST(ACFG_RST))
   u_sh_acfg (
      .clk(clk), .rst_n(rst_n),
      .host_we(mir_we[SH_ACFG]), .host_wdata(wr_data[MIR_W-1:0]),
      .commit(commit), .snap(snap),
      .hw_we(hw_we[SH_ACFG]), .hw_wdata(hw_wdata[ACFG_W-1:0]),
      .mirror_q(mir_q[SH_ACFG]), .hw_q(adc_cfg)
   );

   mrb_shadow #(.MIR_W(MIR_W), .HW_W(RATE_W), .LSB(0), .FIELD_ONLY(1'b0), .RST(RATE_RST))
   u_sh_rate (
      .clk(clk), .rst_n(rst_n),
      .host_we(mir_we[SH_RATE]), .host_wdata(wr_data[MIR_W-1:0]),
      .commit(commit), .snap(snap),
      .hw_we(hw_we[SH_RATE]), .hw_wdata(hw_wdata[RATE_W-1:0]),
      .mirror_q(mir_q[SH_RATE]), .hw_q(adc_rate)
   );

   mrb_shadow #(.MIR_W(MIR_W), .HW_W(ACQ_W), .LSB(0), .FIELD_ONLY(1'b0), .RST(ACQ_RST))
   u_sh_acq (
      .clk(clk), .rst_n(rst_n),
      .host_we(mir_we[SH_ACQ]), .host_wdata(wr_data[MIR_W-1:0]),
      .commit(commit), .snap(snap),
      .hw_we(hw_we[SH_ACQ]), .hw_wdata(hw_wdata[ACQ_W-1:0]),
      .mirror_q(mir_q[SH_ACQ]), .hw_q(adc_acq)
   );

   mrb_shadow #(.MIR_W(MIR_W), .HW_W(SPICF_W), .LSB(0), .FIELD_ONLY(1'b0), .RST(SPICF_RST))
   u_sh_spi (
      .clk(clk), .rst_n(rst_n),
      .host_we(mir_we[SH_SPI]), .host_wdata(wr_data[MIR_W-1:0]),
      .commit(commit), .snap(snap),
      .hw_we(hw_we[SH_SPI]), .hw_wdata(hw_wdata[SPICF_W-1:0]),
      .mirror_q(mir_q[SH_SPI]), .hw_q(spi_cfg)
   );

   mrb_shadow #(.MIR_W(MIR_W), .HW_W(1), .LSB(OPMODE_BIT), .FIELD_ONLY(1'b1), .RST(EXTCLK_RST))
   u_sh_opmode (
      .clk(clk), .rst_n(rst_n),
      .host_we(mir_we[SH_OPMODE]), .host_wdata(wr_data[MIR_W-1:0]),
      .commit(commit), .snap(snap),
      .hw_we(hw_we[SH_OPMODE]), .hw_wdata(hw_wdata[0:0]),
      .mirror_q(mir_q[SH_OPMODE]), .hw_q(ext_q)
   );

   assign ext_clk_sel = ext_q[0];

   logic [DATA_W-1:0] rd16, rd32, rdro;

   mrb_gp_file #(
      .DATA_W  (DATA_W),
      .REG16_W (16),
      .NUM_RW16(NUM_RW16),
      .NUM_RW32(NUM_RW32),
      .NUM_RO  (NUM_RO),
      .IDX_W   (IDX_W)
   ) u_gp (
      .clk      (clk),
      .rst_n    (rst_n),
      .we16     (wr_en && (kind == K_RW16)),
      .we32     (wr_en && (kind == K_RW32)),
      .idx      (idx),
      .wdata    (wr_data),
      .ro_status(ro_status),
      .rd16     (rd16),
      .rd32     (rd32),
      .rdro     (rdro)
   );

   logic [DATA_W-1:0] mir_rd;
   always_comb begin
      mir_rd = '0;
      for (int i = 0; i < NUM_SHADOW; i++) begin
         if (idx == IDX_W'(i)) mir_rd = DATA_W'(mir_q[i]);
      end
   end

   logic [DATA_W-1:0] rd_next;
   always_comb begin
      unique case (kind)
         K_MIRROR: rd_next = mir_rd;
         K_RW16:   rd_next = rd16;
         K_RW32:   rd_next = rd32;
         K_RO:     rd_next = rdro;
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= rd_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_apply <= 1'b0;
      end else begin
         spi_apply <= commit;
      end
   end

endmodule

// File: rtl/mirror_reg_bank_chk.sv
module mirror_reg_bank_chk #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned MIR_W      = 16,
   parameter int unsigned ACFG_W     = 16,
   parameter int unsigned SPICF_W    = 3,
   parameter int unsigned NUM_HW     = 5,
   parameter int unsigned CMD_COMMIT = 32'h900,
   parameter int unsigned CMD_SNAP   = 32'hA00
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               rd_en,
   input logic [NUM_HW-1:0]  hw_we,
   input logic [DATA_W-1:0]  rd_data,
   input logic [ACFG_W-1:0]  adc_cfg,
   input logic [SPICF_W-1:0] spi_cfg,
   input logic               ext_clk_sel,
   input logic               spi_apply,
   input logic [MIR_W-1:0]   mir_spi
);

   logic commit_rd, snap_rd;
   assign commit_rd = rd_en && (addr == ADDR_W'(CMD_COMMIT));
   assign snap_rd   = rd_en && (addr == ADDR_W'(CMD_SNAP));

   p_apply_after_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_rd |=> spi_apply);

   p_apply_only_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_apply |-> $past(commit_rd));

   p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_rd || snap_rd) |=> (rd_data == '0));

   p_hw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_rd && hw_we == '0) |=>
         ($stable(adc_cfg) && $stable(spi_cfg) && $stable(ext_clk_sel)));

   p_commit_spi_r3: assert property (@(posedge clk) disable iff (!rst_n)
      commit_rd |=> (spi_cfg == $past(mir_spi[SPICF_W-1:0])));

   p_snap_spi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      snap_rd |=> (mir_spi == MIR_W'($past(spi_cfg))));

   p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

bind mirror_reg_bank mirror_reg_bank_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .MIR_W     (MIR_W),
   .ACFG_W    (ACFG_W),
   .SPICF_W   (SPICF_W),
   .NUM_HW    (mrb_pkg::NUM_SHADOW),
   .CMD_COMMIT(CMD_COMMIT),
   .CMD_SNAP  (CMD_SNAP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr       (addr),
   .rd_en      (rd_en),
   .hw_we      (hw_we),
   .rd_data    (rd_data),
   .adc_cfg    (adc_cfg),
   .spi_cfg    (spi_cfg),
   .ext_clk_sel(ext_clk_sel),
   .spi_apply  (spi_apply),
   .mir_spi    (mir_q[mrb_pkg::SH_SPI])
);

// File: tb/mirror_reg_bank_tb.sv
module mirror_reg_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [4:0]  hw_we = '0;
   logic [15:0] hw_wdata = '0;
   logic [63:0] ro_status = {32'h5A5A_0001, 32'h0BAD_F00D};
   logic [15:0] adc_cfg, adc_rate, adc_acq;
   logic [2:0]  spi_cfg;
   logic        ext_clk_sel, spi_apply;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mirror_reg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .hw_we(hw_we), .hw_wdata(hw_wdata),
      .ro_status(ro_status), .adc_cfg(adc_cfg), .adc_rate(adc_rate),
      .adc_acq(adc_acq), .spi_cfg(spi_cfg), .ext_clk_sel(ext_clk_sel),
      .spi_apply(spi_apply)
   );

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_HW = 2'd2, OP_OUT = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 47;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,  12'h100, 32'h0,         32'h0000_0040, 4'd1},  // R1 mirror default
      '{OP_RD,  12'h104, 32'h0,         32'h0000_0008, 4'd1},  // R1
      '{OP_OUT, 12'h003, 32'h0,         32'h0000_0000, 4'd1},  // R1 spi mode 0
      '{OP_OUT, 12'h001, 32'h0,         32'h0000_0100, 4'd1},  // R1 rate
      '{OP_WR,  12'h100, 32'h1234,      32'h0,         4'd2},  // R2
      '{OP_WR,  12'h106, 32'h0006,      32'h0,         4'd2},  // R2
      '{OP_WR,  12'h900, 32'h0,         32'h0,         4'd3},  // R3 write to command
      '{OP_OUT, 12'h000, 32'h0,         32'h0000_0040, 4'd2},  // R2 hw untouched
      '{OP_OUT, 12'h003, 32'h0,         32'h0000_0000, 4'd2},  // R2 / R3
      '{OP_RD,  12'h100, 32'h0,         32'h0000_1234, 4'd2},  // R2 mirror readback
      '{OP_RD,  12'h900, 32'h0,         32'h0,         4'd3},  // R3 commit reads 0
      '{OP_OUT, 12'h000, 32'h0,         32'h0000_1234, 4'd3},  // R3
      '{OP_OUT, 12'h003, 32'h0,         32'h0000_0006, 4'd3},  // R3
      '{OP_OUT, 12'h002, 32'h0,         32'h0000_0008, 4'd3},  // R3
      '{OP_WR,  12'h108, 32'hFFEF,      32'h0,         4'd6},  // R6
      '{OP_RD,  12'h900, 32'h0,         32'h0,         4'd3},  // R3
      '{OP_OUT, 12'h004, 32'h0,         32'h0,         4'd6},  // R6 bit4 clear
      '{OP_WR,  12'h108, 32'h0310,      32'h0,         4'd6},  // R6
      '{OP_RD,  12'h900, 32'h0,         32'h0,         4'd3},  // R3
      '{OP_OUT, 12'h004, 32'h0,         32'h0000_0001, 4'd6},  // R6 bit4 set
      '{OP_HW,  12'h002, 32'hABCD,      32'h0,         4'd7},  // R7 rate
      '{OP_OUT, 12'h001, 32'h0,         32'h0000_ABCD, 4'd7},  // R7
      '{OP_RD,  12'h102, 32'h0,         32'h0000_0100, 4'd7},  // R7 mirror kept
      '{OP_HW,  12'h008, 32'hFFFF,      32'h0,         4'd7},  // R7 spi
      '{OP_OUT, 12'h003, 32'h0,         32'h0000_0007, 4'd7},  // R7
      '{OP_HW,  12'h010, 32'h0000,      32'h0,         4'd7},  // R7 ext
      '{OP_OUT, 12'h004, 32'h0,         32'h0,         4'd7},  // R7
      '{OP_RD,  12'hA00, 32'h0,         32'h0,         4'd5},  // R5 snapshot reads 0
      '{OP_RD,  12'h102, 32'h0,         32'h0000_ABCD, 4'd5},  // R5
      '{OP_RD,  12'h106, 32'h0,         32'h0000_0007, 4'd5},  // R5 zero-extended
      '{OP_RD,  12'h108, 32'h0,         32'h0000_0300, 4'd6},  // R6 other bits kept
      '{OP_RD,  12'h100, 32'h0,         32'h0000_1234, 4'd5},  // R5
      '{OP_WR,  12'h200, 32'hDEAD_BEEF, 32'h0,         4'd9},  // R9
      '{OP_RD,  12'h200, 32'h0,         32'h0000_BEEF, 4'd9},  // R9
      '{OP_WR,  12'h304, 32'hCAFE_F00D, 32'h0,         4'd9},  // R9
      '{OP_RD,  12'h304, 32'h0,         32'hCAFE_F00D, 4'd9},  // R9
      '{OP_RD,  12'h300, 32'h0,         32'h0,         4'd9},  // R9 neighbour untouched
      '{OP_WR,  12'h202, 32'hFFFF_5A5A, 32'h0,         4'd9},  // R9
      '{OP_RD,  12'h202, 32'h0,         32'h0000_5A5A, 4'd9},  // R9
      '{OP_WR,  12'h400, 32'h0,         32'h0,         4'd10}, // R10 ignored
      '{OP_RD,  12'h400, 32'h0,         32'h0BAD_F00D, 4'd10}, // R10
      '{OP_RD,  12'h404, 32'h0,         32'h5A5A_0001, 4'd10}, // R10
      '{OP_WR,  12'h7F0, 32'h1,         32'h0,         4'd11}, // R11
      '{OP_RD,  12'h7F0, 32'h0,         32'h0,         4'd11}, // R11
      '{OP_WR,  12'h101, 32'hFFFF,      32'h0,         4'd11}, // R11 misaligned
      '{OP_RD,  12'h101, 32'h0,         32'h0,         4'd11}, // R11
      '{OP_RD,  12'h100, 32'h0,         32'h0000_1234, 4'd11}  // R11 mirror intact
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] out_sel(input logic [2:0] s);
      case (s)
         3'd0:    return 32'(adc_cfg);
         3'd1:    return 32'(adc_rate);
         3'd2:    return 32'(adc_acq);
         3'd3:    return 32'(spi_cfg);
         default: return 32'(ext_clk_sel);
      endcase
   endfunction

   task automatic host_read(input logic [11:0] a);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic host_write(input logic [11:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      string tag;
      tag = $sformatf("R%0d vec addr=%h", v.req, v.addr);
      case (v.op)
         OP_WR: host_write(v.addr, v.data);
         OP_RD: begin
            host_read(v.addr);
            check(tag, rd_data, v.exp);
         end
         OP_HW: begin
            hw_we = v.addr[4:0]; hw_wdata = v.data[15:0];
            @(negedge clk);
            hw_we = '0;
         end
         default: check(tag, out_sel(v.addr[2:0]), v.exp);
      endcase
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 spi_apply low after reset", 32'(spi_apply), 32'h0);
      check("R1 ext_clk_sel reset", 32'(ext_clk_sel), 32'h0);
      check("R1 adc_acq reset", 32'(adc_acq), 32'h8);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R12: rd_data holds while rd_en is low
      host_read(12'h102);
      check("R12 read value", rd_data, 32'h0000_ABCD);
      addr = 12'h100;
      @(negedge clk);
      check("R12 hold without rd_en", rd_data, 32'h0000_ABCD);

      // R8 and R4: commit and side channel on the same edge
      addr = 12'h900; rd_en = 1'b1; hw_we = 5'b00001; hw_wdata = 16'h5555;
      @(negedge clk);
      rd_en = 1'b0; hw_we = '0;
      check("R8 commit beats hw_we", 32'(adc_cfg), 32'h0000_1234);
      check("R4 apply pulse after commit", 32'(spi_apply), 32'h1);
      @(negedge clk);
      check("R4 apply pulse one cycle", 32'(spi_apply), 32'h0);

      // R4: snapshot raises no apply
      host_read(12'hA00);
      check("R4 no apply on snapshot", 32'(spi_apply), 32'h0);

      // R1: reset mid-run restores defaults
      host_write(12'h106, 32'h5);
      host_read(12'h900);
      check("R3 spi from mirror", 32'(spi_cfg), 32'h5);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 spi_cfg default", 32'(spi_cfg), 32'h0);
      check("R1 adc_cfg default", 32'(adc_cfg), 32'h40);
      host_read(12'h106);
      check("R1 spi mirror default", rd_data, 32'h0);
      host_read(12'h108);
      check("R1 opmode mirror default", rd_data, 32'h0);
      host_read(12'h200);
      check("R1 general register cleared", rd_data, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule